// File: doc/BRIEF.md
# Overload Retry and Thermal Power-Enable Sequencer

This block decides, cycle by cycle, whether the output power stage of a supply regulator may be switched on. It watches an already synchronized overload comparator and a pair of thermal comparators (a trip level and a lower recovery level), and takes the master enable bit and the clamp-mode bit from the control register. It drives the power-enable line and two status flags: an overload flag and an over-temperature flag.

Two overload policies are offered. With the clamp-mode bit high the analog current clamp does the protecting, the power stage stays on, and the overload flag simply follows the comparator. With the clamp-mode bit low the block runs a retry cycle: on an overload it switches the stage off for a long off-interval, then turns it back on for a short trial window (one tenth of the off-interval by default), and repeats until a whole trial window passes with no overload. Both intervals are counted in ticks of a one-millisecond strobe that arrives as a single-cycle pulse, so a bench or a faster system can shrink them through parameters.

All pins are plain control and status levels; there is no data stream and no handshake. Thermal protection overrides everything and uses the two comparator levels for hysteresis.

Top module: `overload_power_sequencer`

## Requirements
- R1: With the master enable high, clamp-mode low and the sequencer in normal operation, an overload sampled at a clock edge makes the power-enable low and the overload flag high from that edge on.
- R2: The off-interval ends on exactly the OFF_TICKS-th tick strobe counted after the edge that entered it; clock cycles without a strobe do not advance it. At that edge power-enable returns high while the overload flag stays high.
- R3: If the overload input is high in any cycle of the trial window, including the cycle of its final strobe, the edge of the ON_TICKS-th strobe returns the sequencer to a new full off-interval with power-enable low.
- R4: If a trial window of ON_TICKS strobes passes with the overload input low throughout, the overload flag goes low at the edge of its final strobe and normal operation resumes with power-enable high.
- R5: With clamp-mode high and the master enable high, power-enable stays high under overload and the overload flag equals the overload input sampled at the previous edge.
- R6: The over-temperature flag is set at the edge after the trip comparator is high, stays set while the recovery comparator is low, and clears at the edge where the recovery comparator is high and the trip comparator is low; while it is set, power-enable is low.
- R7: With the master enable low, power-enable is low in the same cycle, and from the next edge the sequencer is idle with the overload flag low; raising the enable again turns power on in the same cycle.
- R8: Lowering clamp-mode while an overload is present starts an off-interval at the next edge; raising clamp-mode during an off-interval or a trial window leaves the retry cycle at the next edge, with power-enable high and the overload flag following the overload input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ms_tick_i | input | 1 | One-cycle strobe, once per millisecond |
| en_i | input | 1 | Master enable bit from the control register |
| clamp_mode_i | input | 1 | 1 = static clamp policy, 0 = timed retry policy |
| ovl_i | input | 1 | Synchronized overload comparator |
| ot_trip_i | input | 1 | Temperature above the shutdown level |
| ot_cool_i | input | 1 | Temperature below the recovery level |
| pwr_en_o | output | 1 | Power stage enable |
| ovl_flag_o | output | 1 | Overload status flag |
| ot_flag_o | output | 1 | Over-temperature status flag |

## Verification
The overload detector and the thermal trip can both act on the same edge: the bench raises the overload and trip comparators together in retry mode and expects both flags set and power off one cycle later, then clears the thermal condition and expects power to stay off because the off-interval still runs. A second coincidence is the last strobe of a trial window arriving in the same cycle as a fresh overload; the bench drives both together and expects a new off-interval rather than recovery.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_OFF  = 2'd2,
    SEQ_ON   = 2'd3
  } seq_state_e;

endpackage

// File: rtl/pwrseq_tick_timer.sv
module pwrseq_tick_timer #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear_i,
  input  logic         tick_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);

  logic [W-1:0] cnt_q;
  logic         at_last;

  assign at_last  = (cnt_q == limit_i - W'(1));
  assign expire_o = tick_i && at_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clear_i) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      cnt_q <= at_last ? '0 : cnt_q + W'(1);
    end
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < limit_i); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !clear_i) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/pwrseq_thermal_latch.sv
module pwrseq_thermal_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic trip_i,
  input  logic cool_i,
  output logic otf_o
);

  logic otf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      otf_q <= 1'b0;
    end else if (trip_i) begin
      otf_q <= 1'b1;
    end else if (cool_i) begin
      otf_q <= 1'b0;
    end
  end

  assign otf_o = otf_q;

  AST_OT_SET: assert property (@(posedge clk) disable iff (!rst_n)
    trip_i |=> otf_o); // R6

  AST_OT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (otf_o && !cool_i) |=> otf_o); // R6

  AST_OT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (cool_i && !trip_i) |=> !otf_o); // R6

endmodule

// File: rtl/pwrseq_ovl_fsm.sv
module pwrseq_ovl_fsm
  import pwrseq_pkg::*;
#(
  parameter int OFF_TICKS = 900,
  parameter int ON_TICKS  = 90,
  parameter int W         = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         clamp_mode_i,
  input  logic         ovl_i,
  input  logic         expire_i,
  output seq_state_e   state_o,
  output logic         olf_o,
  output logic         clear_o,
  output logic [W-1:0] limit_o
);

  seq_state_e st_q, st_d;
  logic       olf_q, olf_d;
  logic       seen_q, seen_d;
  logic       hit;

  assign hit = seen_q || ovl_i;

  always_comb begin
    st_d   = st_q;
    olf_d  = olf_q;
    seen_d = seen_q;
    if (!en_i) begin
      st_d   = SEQ_IDLE;
      olf_d  = 1'b0;
      seen_d = 1'b0;
    end else begin
      case (st_q)
        SEQ_IDLE, SEQ_RUN: begin
          if (clamp_mode_i) begin
            st_d  = SEQ_RUN;
            olf_d = ovl_i;
          end else if (ovl_i) begin
            st_d  = SEQ_OFF;
            olf_d = 1'b1;
          end else begin
            st_d  = SEQ_RUN;
            olf_d = 1'b0;
          end
        end
        SEQ_OFF: begin
          if (clamp_mode_i) begin
            st_d  = SEQ_RUN;
            olf_d = ovl_i;
          end else if (expire_i) begin
            st_d   = SEQ_ON;
            seen_d = 1'b0;
          end
        end
        SEQ_ON: begin
          if (clamp_mode_i) begin
            st_d   = SEQ_RUN;
            olf_d  = ovl_i;
            seen_d = 1'b0;
          end else begin
            seen_d = hit;
            if (expire_i) begin
              seen_d = 1'b0;
              if (hit) begin
                st_d = SEQ_OFF;
              end else begin
                st_d  = SEQ_RUN;
                olf_d = 1'b0;
              end
            end
          end
        end
        default: st_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SEQ_IDLE;
      olf_q  <= 1'b0;
      seen_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      olf_q  <= olf_d;
      seen_q <= seen_d;
    end
  end

  assign clear_o = (st_d != st_q) || (st_q == SEQ_RUN) || (st_q == SEQ_IDLE);
  assign limit_o = (st_q == SEQ_OFF) ? W'(OFF_TICKS) : W'(ON_TICKS);
  assign state_o = st_q;
  assign olf_o   = olf_q;

  AST_DYN_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clamp_mode_i && ovl_i && (st_q == SEQ_RUN || st_q == SEQ_IDLE))
    |=> (st_q == SEQ_OFF && olf_q)); // R1

  AST_OFF_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == SEQ_OFF) |-> olf_q); // R2

  AST_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clamp_mode_i && st_q == SEQ_ON && expire_i && (seen_q || ovl_i))
    |=> (st_q == SEQ_OFF)); // R3

  AST_CLEAN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !clamp_mode_i && st_q == SEQ_ON && expire_i && !seen_q && !ovl_i)
    |=> (st_q == SEQ_RUN && !olf_q)); // R4

  AST_STATIC_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clamp_mode_i) |=> (olf_q == $past(ovl_i))); // R5

  AST_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (st_q == SEQ_IDLE && !olf_q)); // R7

  AST_MODE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clamp_mode_i && (st_q == SEQ_OFF || st_q == SEQ_ON))
    |=> (st_q == SEQ_RUN)); // R8

endmodule

// File: rtl/overload_power_sequencer.sv
module overload_power_sequencer
  import pwrseq_pkg::*;
#(
  parameter int OFF_TICKS = 900,
  parameter int ON_TICKS  = OFF_TICKS / 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick_i,
  input  logic en_i,
  input  logic clamp_mode_i,
  input  logic ovl_i,
  input  logic ot_trip_i,
  input  logic ot_cool_i,
  output logic pwr_en_o,
  output logic ovl_flag_o,
  output logic ot_flag_o
);

  localparam int MAX_TICKS = (OFF_TICKS > ON_TICKS) ? OFF_TICKS : ON_TICKS;
  localparam int W         = $clog2(MAX_TICKS + 1);

  seq_state_e   seq_state;
  logic         tmr_clear;
  logic         tmr_expire;
  logic [W-1:0] tmr_limit;
  logic         otf;

  pwrseq_ovl_fsm #(
    .OFF_TICKS (OFF_TICKS),
    .ON_TICKS  (ON_TICKS),
    .W         (W)
  ) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (en_i),
    .clamp_mode_i (clamp_mode_i),
    .ovl_i        (ovl_i),
    .expire_i     (tmr_expire),
    .state_o      (seq_state),
    .olf_o        (ovl_flag_o),
    .clear_o      (tmr_clear),
    .limit_o      (tmr_limit)
  );

  pwrseq_tick_timer #(
    .W (W)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (tmr_clear),
    .tick_i   (ms_tick_i),
    .limit_i  (tmr_limit),
    .expire_o (tmr_expire)
  );

  pwrseq_thermal_latch u_thermal (
    .clk    (clk),
    .rst_n  (rst_n),
    .trip_i (ot_trip_i),
    .cool_i (ot_cool_i),
    .otf_o  (otf)
  );

  assign ot_flag_o = otf;
  assign pwr_en_o  = en_i && !otf && (seq_state != SEQ_OFF);

  AST_STATIC_STAYS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && clamp_mode_i && !ot_trip_i && !otf) |=> (pwr_en_o || !en_i || ot_flag_o)); // R5

endmodule

// File: tb/test_overload_power_sequencer.sv
`timescale 1ns/1ps
module test_overload_power_sequencer;

  localparam int OFF_T = 20;
  localparam int ON_T  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0;
  logic en = 1'b0;
  logic clamp = 1'b0;
  logic ovl = 1'b0;
  logic trip = 1'b0;
  logic cool = 1'b0;
  logic pwr_en, olf, otf;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  overload_power_sequencer #(.OFF_TICKS(OFF_T), .ON_TICKS(ON_T)) i_overload_power_sequencer (
    .clk          (clk),
    .rst_n        (rst_n),
    .ms_tick_i    (ms_tick),
    .en_i         (en),
    .clamp_mode_i (clamp),
    .ovl_i        (ovl),
    .ot_trip_i    (trip),
    .ot_cool_i    (cool),
    .pwr_en_o     (pwr_en),
    .ovl_flag_o   (olf),
    .ot_flag_o    (otf)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ms_tick = 1'b1;
      @(negedge clk);
      ms_tick = 1'b0;
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R7 reset pwr_en", pwr_en, 1'b0);
    chk("R7 reset ovl flag", olf, 1'b0);
    chk("R6 reset ot flag", otf, 1'b0);
  endtask

  task automatic t_static;
    en = 1'b1; clamp = 1'b1;
    step(1);
    chk("R7 enable turns power on", pwr_en, 1'b1);
    ovl = 1'b1; step(1);
    chk("R5 static flag follows overload", olf, 1'b1);
    chk("R5 static power stays on", pwr_en, 1'b1);
    step(3);
    chk("R5 static power on under lasting overload", pwr_en, 1'b1);
    ovl = 1'b0; step(1);
    chk("R5 static flag clears", olf, 1'b0);
  endtask

  task automatic t_dynamic;
    clamp = 1'b0; step(1);
    ovl = 1'b1; step(1);
    chk("R1 overload cuts power", pwr_en, 1'b0);
    chk("R1 overload sets flag", olf, 1'b1);
    ovl = 1'b0;
    step(50);
    chk("R2 no strobe no progress", pwr_en, 1'b0);
    ticks(OFF_T - 1);
    chk("R2 off before last strobe", pwr_en, 1'b0);
    ticks(1);
    chk("R2 power back after off interval", pwr_en, 1'b1);
    chk("R2 flag held in trial window", olf, 1'b1);
    ticks(ON_T - 1);
    chk("R4 flag still high before window end", olf, 1'b1);
    ticks(1);
    chk("R4 clean window clears flag", olf, 1'b0);
    chk("R4 clean window keeps power", pwr_en, 1'b1);
  endtask

  task automatic t_retry;
    ovl = 1'b1; step(1); ovl = 1'b0;
    ticks(OFF_T);
    chk("R3 trial window power on", pwr_en, 1'b1);
    ovl = 1'b1; step(1); ovl = 1'b0;
    chk("R3 power stays on inside window", pwr_en, 1'b1);
    ticks(ON_T);
    chk("R3 overload in window restarts off", pwr_en, 1'b0);
    chk("R3 flag high after retry", olf, 1'b1);
    ticks(OFF_T - 1);
    chk("R3 full off interval again", pwr_en, 1'b0);
    ticks(1);
    chk("R3 second trial window", pwr_en, 1'b1);
    ticks(ON_T - 1);
    ovl = 1'b1; ms_tick = 1'b1;
    step(1);
    ovl = 1'b0; ms_tick = 1'b0;
    step(1);
    chk("R3 overload on final strobe restarts off", pwr_en, 1'b0);
    ticks(OFF_T + ON_T);
    chk("R4 recovery after retries", olf, 1'b0);
    chk("R4 power on after retries", pwr_en, 1'b1);
  endtask

  task automatic t_mode;
    clamp = 1'b1; ovl = 1'b1; step(1);
    chk("R5 static overload flagged", olf, 1'b1);
    clamp = 1'b0; step(1);
    chk("R8 clamp low with overload starts off", pwr_en, 1'b0);
    clamp = 1'b1; step(1);
    chk("R8 clamp high leaves off interval", pwr_en, 1'b1);
    chk("R8 flag follows overload after exit", olf, 1'b1);
    ovl = 1'b0; step(1);
    chk("R8 flag follows cleared overload", olf, 1'b0);
    clamp = 1'b0; step(1);
  endtask

  task automatic t_enable;
    ovl = 1'b1; step(1); ovl = 1'b0;
    chk("R1 off before disable", pwr_en, 1'b0);
    en = 1'b0; #2;
    chk("R7 disable power same cycle", pwr_en, 1'b0);
    step(1);
    chk("R7 disable clears flag", olf, 1'b0);
    en = 1'b1; #2;
    chk("R7 reenable power same cycle", pwr_en, 1'b1);
    step(1);
    chk("R7 reenable normal operation", pwr_en, 1'b1);
    en = 1'b0; #2;
    chk("R7 disable from run cuts power", pwr_en, 1'b0);
    step(1);
    en = 1'b1; step(1);
  endtask

  task automatic t_thermal;
    trip = 1'b1; step(1);
    chk("R6 trip sets flag", otf, 1'b1);
    chk("R6 trip cuts power", pwr_en, 1'b0);
    trip = 1'b0; step(3);
    chk("R6 flag held between levels", otf, 1'b1);
    chk("R6 power held off between levels", pwr_en, 1'b0);
    cool = 1'b1; step(1);
    chk("R6 recovery clears flag", otf, 1'b0);
    chk("R6 recovery restores power", pwr_en, 1'b1);
    cool = 1'b0; step(1);
  endtask

  task automatic t_same_cycle;
    ovl = 1'b1; trip = 1'b1; step(1);
    ovl = 1'b0; trip = 1'b0;
    chk("R1 overload flag with thermal trip", olf, 1'b1);
    chk("R6 thermal flag with overload", otf, 1'b1);
    chk("R6 power off on both", pwr_en, 1'b0);
    cool = 1'b1; step(1); cool = 1'b0;
    chk("R6 thermal cleared", otf, 1'b0);
    chk("R2 off interval still holds power", pwr_en, 1'b0);
    ticks(OFF_T);
    chk("R2 power after off interval", pwr_en, 1'b1);
    ticks(ON_T);
    chk("R4 flag cleared after coincidence", olf, 1'b0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_static();
    t_dynamic();
    t_retry();
    t_mode();
    t_enable();
    t_thermal();
    t_same_cycle();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule